// File: doc/BRIEF.md
# TDM Bus Clock Selector and 8 kHz Reference Generator

This block supplies the timing for a TDM bus port. All of its logic runs on the 16.384 MHz master clock. In slave mode it takes three inputs from the bus: a double-rate bit clock, a single-rate bit clock and a frame sync. It resynchronises them and passes them on as the local timing signals. The double-rate clock comes from either a single-ended line or the output of a differential receiver. The single-rate clock comes either from its pin or from dividing the double-rate clock by two. In master mode the block makes the bus clocks itself from a frame counter and drives them onto the bus pins. It also drives an inverted copy of the double-rate clock.

In both modes the block produces an 8 kHz reference output. A two-bit select picks the source: an external 8 kHz input, a secondary 8 kHz input, a programmable divider, or the local frame sync. The divider runs on a power-of-two prescale of the master clock and has a programmable length. A free-run flag goes high when the selected reference has shown no rising edge for a fixed number of master-clock cycles.

Top module: `tdm_clk_ref_gen`

## Requirements
- R1: In slave mode, loc_x2, loc_fsync and loc_x1 (when it is taken from its pin) equal the bus inputs delayed by two master-clock cycles of synchronisation.
- R2: cfg_x2_diff=1 takes the double-rate clock from x2_diff_in. cfg_x2_diff=0 takes it from x2_se_in. The input that is not selected has no effect on loc_x2.
- R3: cfg_x1_derive=1 in slave mode makes loc_x1 a register that toggles one cycle after each rising edge of loc_x2. It resets to 0, and x1_in then has no effect.
- R4: In slave mode, x2_oe, x1_oe and fsync_oe are all 0, so every bus pin is high-impedance.
- R5: In master mode, a frame counter wraps every FRAME_CYC cycles. x2_out is counter bit 1 and x1_out is counter bit 2. fsync_out is 1 in the last count of the frame. x2n_out is the inverse of x2_out. All three output enables are 1, and the loc_* signals follow the generated signals.
- R6: ref8k_out is registered from the source chosen by cfg_ref_sel: 0 = synchronised ext8k_in, 1 = synchronised sec8k_in, 2 = divider, 3 = loc_fsync.
- R7: The divider advances once every 2^cfg_prescale master cycles. Its period is cfg_div_len+1 advances, and it is high during the first (cfg_div_len+1)/2 of them (rounded down).
- R8: The reference output works the same way in master mode and in slave mode.
- R9: freerun is 1 after reset. It rises after LOSS_CYC cycles with no rising edge on ref8k_out, and it falls in the cycle after a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = timing master, 0 = timing slave |
| cfg_x2_diff | input | 1 | Double-rate clock input select |
| cfg_x1_derive | input | 1 | Derive single-rate clock from double-rate clock |
| cfg_ref_sel | input | 2 | Reference source select |
| cfg_prescale | input | 2 | Divider prescale exponent |
| cfg_div_len | input | LEN_W | Divider period minus one |
| x2_se_in | input | 1 | Single-ended double-rate clock |
| x2_diff_in | input | 1 | Differential receiver output |
| x1_in | input | 1 | Single-rate clock pin input |
| fsync_in | input | 1 | Frame sync pin input |
| ext8k_in | input | 1 | External 8 kHz input |
| sec8k_in | input | 1 | Secondary 8 kHz input |
| x2_out | output | 1 | Generated double-rate clock |
| x2n_out | output | 1 | Inverted double-rate clock |
| x2_oe | output | 1 | Double-rate clock pin enable |
| x1_out | output | 1 | Generated single-rate clock |
| x1_oe | output | 1 | Single-rate clock pin enable |
| fsync_out | output | 1 | Generated frame sync |
| fsync_oe | output | 1 | Frame sync pin enable |
| loc_x2 | output | 1 | Local double-rate timing |
| loc_x1 | output | 1 | Local single-rate timing |
| loc_fsync | output | 1 | Local frame sync |
| ref8k_out | output | 1 | 8 kHz reference output |
| freerun | output | 1 | Reference missing flag |

## Verification
The slave path is exercised with bus clocks that have different periods on the single-ended and differential lines. A mixed-up input select or single-rate source therefore shows up as the wrong toggle rate. The divider is run at minimum length, at odd and even lengths with several prescales, and at full length. These cases separate prescale faults from count faults and from rounding faults in the duty cycle. The external and secondary inputs toggle at different rates, and the reference is stopped and restarted. This shows that the select decodes correctly and that freerun rises after the loss window and clears on the next edge, in both modes.

// File: rtl/tdm_clk_ref_gen.sv
module tdm_clk_ref_gen #(
  parameter int FRAME_CYC = 2048,
  parameter int LEN_W     = 14,
  parameter int LOSS_CYC  = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             cfg_x2_diff,
  input  logic             cfg_x1_derive,
  input  logic [1:0]       cfg_ref_sel,
  input  logic [1:0]       cfg_prescale,
  input  logic [LEN_W-1:0] cfg_div_len,
  input  logic             x2_se_in,
  input  logic             x2_diff_in,
  input  logic             x1_in,
  input  logic             fsync_in,
  input  logic             ext8k_in,
  input  logic             sec8k_in,
  output logic             x2_out,
  output logic             x2n_out,
  output logic             x2_oe,
  output logic             x1_out,
  output logic             x1_oe,
  output logic             fsync_out,
  output logic             fsync_oe,
  output logic             loc_x2,
  output logic             loc_x1,
  output logic             loc_fsync,
  output logic             ref8k_out,
  output logic             freerun
);
  localparam int FC_W = $clog2(FRAME_CYC);
  localparam int LC_W = $clog2(LOSS_CYC + 1);

  logic [4:0]       sa, sb;
  logic             x2_d, x1_div;
  logic [FC_W-1:0]  mcnt;
  logic [2:0]       pcnt, pmask;
  logic             ptick;
  logic [LEN_W-1:0] dcnt;
  logic [LEN_W:0]   half;
  logic             div_q, ref_mux, ref_q, ref_d;
  logic [LC_W-1:0]  lcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sec8k_in, ext8k_in, fsync_in, x1_in, cfg_x2_diff ? x2_diff_in : x2_se_in};
      sb <= sa;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x2_d   <= 1'b0;
      x1_div <= 1'b0;
    end else begin
      x2_d <= sb[0];
      if (sb[0] && !x2_d) x1_div <= ~x1_div;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mcnt <= '0;
    else        mcnt <= (mcnt == FC_W'(FRAME_CYC - 1)) ? '0 : mcnt + 1'b1;
  end

  assign x2_out    = mcnt[1];
  assign x2n_out   = ~mcnt[1];
  assign x1_out    = mcnt[2];
  assign fsync_out = (mcnt == FC_W'(FRAME_CYC - 1));
  assign x2_oe     = cfg_master;
  assign x1_oe     = cfg_master;
  assign fsync_oe  = cfg_master;

  assign loc_x2    = cfg_master ? x2_out    : sb[0];
  assign loc_x1    = cfg_master ? x1_out    : (cfg_x1_derive ? x1_div : sb[1]);
  assign loc_fsync = cfg_master ? fsync_out : sb[2];

  assign pmask = 3'((4'd1 << cfg_prescale) - 4'd1);
  assign ptick = (pcnt & pmask) == pmask;
  assign half  = ({1'b0, cfg_div_len} + 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt  <= '0;
      dcnt  <= '0;
      div_q <= 1'b0;
    end else begin
      pcnt  <= pcnt + 1'b1;
      if (ptick) dcnt <= (dcnt >= cfg_div_len) ? '0 : dcnt + 1'b1;
      div_q <= {1'b0, dcnt} < half;
    end
  end

  always_comb begin
    case (cfg_ref_sel)
      2'd0:    ref_mux = sb[3];
      2'd1:    ref_mux = sb[4];
      2'd2:    ref_mux = div_q;
      default: ref_mux = loc_fsync;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      ref_d <= 1'b0;
      lcnt  <= LC_W'(LOSS_CYC);
    end else begin
      ref_q <= ref_mux;
      ref_d <= ref_q;
      if (ref_q && !ref_d)                lcnt <= '0;
      else if (lcnt != LC_W'(LOSS_CYC))   lcnt <= lcnt + 1'b1;
    end
  end

  assign ref8k_out = ref_q;
  assign freerun   = (lcnt == LC_W'(LOSS_CYC));
endmodule

// File: rtl/tdm_clk_ref_chk.sv
module tdm_clk_ref_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_x1_derive,
  input logic x2_out,
  input logic x2n_out,
  input logic x2_oe,
  input logic x1_oe,
  input logic fsync_oe,
  input logic loc_x2,
  input logic loc_x1,
  input logic ref8k_out,
  input logic freerun
);
  p_slave_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!x2_oe && !x1_oe && !fsync_oe));

  p_inverted_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x2_oe |-> (x2n_out != x2_out));

  p_derive_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cfg_x1_derive && $past(!cfg_master && cfg_x1_derive) && $changed(loc_x1))
      |-> ($past(loc_x2) && !$past(loc_x2, 2)));

  p_clear_after_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref8k_out) |=> !freerun);

  p_clear_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freerun) |-> ($past(ref8k_out) && !$past(ref8k_out, 2)));
endmodule

bind tdm_clk_ref_gen tdm_clk_ref_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_x1_derive(cfg_x1_derive),
  .x2_out(x2_out), .x2n_out(x2n_out), .x2_oe(x2_oe), .x1_oe(x1_oe), .fsync_oe(fsync_oe),
  .loc_x2(loc_x2), .loc_x1(loc_x1), .ref8k_out(ref8k_out), .freerun(freerun)
);

// File: tb/tdm_clk_ref_gen_tb_top.sv
`timescale 1ns/1ps
module tdm_clk_ref_gen_tb_top;
  localparam int FRAME = 2048;
  localparam int LOSS  = 4096;

  logic clk = 0, rst_n = 0;
  logic cfg_master = 0, cfg_x2_diff = 0, cfg_x1_derive = 0;
  logic [1:0] cfg_ref_sel = 0, cfg_prescale = 0;
  logic [13:0] cfg_div_len = 0;
  logic x2_se_in = 0, x2_diff_in = 0, x1_in = 0, fsync_in = 0, ext8k_in = 0, sec8k_in = 0;
  logic x2_out, x2n_out, x2_oe, x1_out, x1_oe, fsync_out, fsync_oe;
  logic loc_x2, loc_x1, loc_fsync, ref8k_out, freerun;

  always #10 clk = ~clk;

  tdm_clk_ref_gen dut_i (.*);

  int checks = 0, fails = 0, cyc = 0;
  int bus_run = 0, ext_per = 0, sec_per = 0;

  // stimulus generator: drives bus pins a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (bus_run != 0) begin
      x2_se_in   <= (cyc / 3) % 2;
      x2_diff_in <= (cyc / 5) % 2;
      x1_in      <= (cyc / 7) % 2;
      fsync_in   <= (cyc % 50) == 0;
    end
    if (ext_per != 0) ext8k_in <= (cyc % ext_per) < ext_per / 2;
    if (sec_per != 0) sec8k_in <= (cyc % sec_per) < sec_per / 3;
  end

  // behavioural reference model
  int s1[5], s2[5];
  int m_x2d, m_x1div, m_fc, m_pc, m_dc, m_div, m_ref, m_refd, m_gap;

  function automatic int e_x2();  return cfg_master ? (m_fc / 2) % 2 : s2[0]; endfunction
  function automatic int e_x1();
    if (cfg_master) return (m_fc / 4) % 2;
    return cfg_x1_derive ? m_x1div : s2[1];
  endfunction
  function automatic int e_fs();  return cfg_master ? int'(m_fc == FRAME - 1) : s2[2]; endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (s1[i]) begin s1[i] = 0; s2[i] = 0; end
      m_x2d = 0; m_x1div = 0; m_fc = 0; m_pc = 0; m_dc = 0; m_div = 0;
      m_ref = 0; m_refd = 0; m_gap = LOSS;
    end else begin
      int nref, step, len, hi;
      case (cfg_ref_sel)
        0: nref = s2[3];
        1: nref = s2[4];
        2: nref = m_div;
        default: nref = e_fs();
      endcase
      if (m_ref == 1 && m_refd == 0) m_gap = 0;
      else if (m_gap < LOSS) m_gap++;
      m_refd = m_ref;
      m_ref = nref;
      len = int'(cfg_div_len);
      hi = (len + 1) / 2;
      step = 1 << cfg_prescale;
      m_div = (m_dc < hi) ? 1 : 0;
      if ((m_pc % step) == step - 1) m_dc = (m_dc >= len) ? 0 : m_dc + 1;
      m_pc = (m_pc + 1) % 8;
      m_fc = (m_fc + 1) % FRAME;
      if (s2[0] == 1 && m_x2d == 0) m_x1div ^= 1;
      m_x2d = s2[0];
      s2 = s1;
      s1[0] = cfg_x2_diff ? x2_diff_in : x2_se_in;
      s1[1] = x1_in; s1[2] = fsync_in; s1[3] = ext8k_in; s1[4] = sec8k_in;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      string tt, rt;
      tt = cfg_master ? "R5" : (cfg_x1_derive ? "R3" : (cfg_x2_diff ? "R2" : "R1"));
      rt = cfg_master ? "R8" : (cfg_ref_sel == 2 ? "R7" : "R6");
      chk(tt, {loc_x2, loc_x1, loc_fsync}, {e_x2() != 0, e_x1() != 0, e_fs() != 0});
      chk(cfg_master ? "R5" : "R4", {x2_oe, x1_oe, fsync_oe}, {3{cfg_master}});
      if (cfg_master) chk("R5", {x2_out, x2n_out, x1_out, fsync_out},
                          {e_x2() != 0, e_x2() == 0, e_x1() != 0, e_fs() != 0});
      chk(rt, ref8k_out, m_ref);
      chk("R9", freerun, m_gap == LOSS);
    end
  end

  task automatic run(int n); repeat (n) @(posedge clk); #5; endtask

  initial begin
    run(3);
    checks++; if (freerun !== 1'b1 || ref8k_out !== 1'b0 || x1_oe !== 1'b0) begin
      fails++; $display("FAIL R9 reset: freerun %b ref %b expected 1 0", freerun, ref8k_out);
    end
    rst_n = 1;
    bus_run = 1; ext_per = 100; sec_per = 70;
    run(500);                                            // R1 slave, single-ended, pin x1
    cfg_x2_diff = 1; run(500);                           // R2 differential select
    cfg_x1_derive = 1; run(500);                         // R3 derived x1
    cfg_x2_diff = 0; run(500);
    cfg_ref_sel = 1; run(500);                           // R6 secondary source
    cfg_ref_sel = 3; run(500);                           // R6 frame sync source
    cfg_ref_sel = 2; cfg_div_len = 1; run(300);          // R7 minimum useful length
    cfg_div_len = 6; cfg_prescale = 2; run(600);         // R7 odd period rounding
    cfg_div_len = 9; cfg_prescale = 3; run(900);
    cfg_div_len = 0; run(LOSS + 50);                     // R9 divider stuck low -> loss
    cfg_div_len = 16383; cfg_prescale = 0; run(17000);   // R7 full length, R9 loss in high phase
    cfg_ref_sel = 0; ext_per = 0; ext8k_in = 0; run(LOSS + 100); // R9 stopped source
    ext_per = 100; run(400);                             // R9 recovery
    cfg_master = 1; run(FRAME + 200);                    // R5 master generation, R8
    cfg_ref_sel = 3; run(2 * FRAME + 100);               // R8 frame ref in master
    cfg_ref_sel = 2; cfg_div_len = 2047; run(3000);
    cfg_master = 0; cfg_x1_derive = 0; run(500);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule